// File: doc/BRIEF.md
# SPI Byte-Wide Memory Slave

This block is the slave side of an SPI memory. A host selects it with an active-low chip select. It sends an 8-bit command, and for array access a 16-bit address, most significant byte first. It then streams data bytes in or out. Each stream runs through an address counter that steps by one after every byte. Array bytes are stored the moment their last bit arrives, so there is no busy phase and the next byte may follow at once.

A small status register is reachable over the same link. Writes to it are guarded by a write-enable latch and by a write-protect pin. A hold pin lets the host park a transfer mid-byte and later pick it up exactly where it stopped.

All pins are oversampled by a system clock that runs several times faster than SCK. The address space is 15 bits. The physical storage is sized by `MEM_AW` and holds the low address bits. Set `MEM_AW` equal to `ADDR_W` for the full 32,768 bytes.

Top module: `spi_nvram_slave`

## Requirements
- R1: After reset the output enable is low, the write-enable latch is clear, and a status read returns 0x00.
- R2: Command 0x06 sets the write-enable latch and command 0x04 clears it. The latch is visible as bit 1 of the status byte.
- R3: Command 0x03 (read) and command 0x02 (write) each take two address bytes, high byte first. Address bit 15 is ignored. Each write data byte lands in the array as soon as its eighth bit is sampled.
- R4: The address counter steps by one after every data byte of a burst and wraps from 0x7FFF to 0x0000.
- R5: With the write-enable latch clear, array writes and status writes are discarded.
- R6: With the protect pin low, status writes are discarded. Array writes still succeed.
- R7: The write-enable latch clears at the chip-select rising edge that ends a write or status-write command (0x01).
- R8: SO is enabled only while read data or status bits are being shifted out. It is never enabled while chip select is high or during a write.
- R9: While hold is low, SCK and chip-select changes are ignored, the output enable is low, and the transfer resumes intact once hold returns high.
- R10: A hold transition made while SCK is high is ignored and the transfer carries on.
- R11: A byte cut short by chip select rising is discarded and the command decoder returns to idle.
- R12: SI is sampled on rising SCK and SO changes only on falling SCK. This works with SCK idling low (mode 0) or idling high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from host |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low transfer pause |
| wp_n | input | 1 | Active-low status write protect |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for so |

## Verification
Multi-byte bursts check the address counter, including one across the 0x7FFF boundary, which separates a wrapping counter from a saturating or widened one. Writes are tried with the latch set and clear, and with the protect pin high and low, so that array protection and status protection are told apart. Transfers are interrupted in three ways: by a legal hold, by a hold edge made during high SCK, and by chip select rising mid-byte. These show whether the bit counter freezes, keeps running, or resets. One burst in mode 3 confirms that the leading falling edge does not disturb the decoder.

// File: rtl/spi_nvram_slave.sv
`timescale 1ns/1ps
module spi_nvram_slave #(
  parameter int ADDR_W = 15,
  parameter int MEM_AW = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe
);
  localparam int DEPTH = 1 << MEM_AW;

  typedef enum logic [2:0] {ST_OP, ST_ADR, ST_WR, ST_RD, ST_WSR, ST_RSR, ST_SKIP} st_t;

  st_t st;
  logic sck_r, hold_r, held, cs_eff;
  logic [2:0] bcnt;
  logic abyte, is_wr, wel, clr_wel, so_r, rd_on;
  logic [6:0] sh;
  logic [2:0] srw;
  logic [ADDR_W-1:0] addr;
  logic [7:0] mem [DEPTH];

  wire active    = ~held & ~cs_eff;
  wire rise      = active & sck & ~sck_r;
  wire fall      = active & ~sck & sck_r;
  wire [7:0] bin = {sh, si};
  wire byte_done = rise && bcnt == 3'd7;
  wire cs_rise   = ~held & cs_n & ~cs_eff;
  wire [7:0] status   = {srw[2], 3'b000, srw[1:0], wel, 1'b0};
  wire [7:0] rd_byte  = mem[addr[MEM_AW-1:0]];
  wire [7:0] out_byte = (st == ST_RSR) ? status : rd_byte;
  wire mem_we = byte_done && st == ST_WR && wel;
  wire [ADDR_W+7:0] adr_sh = {addr, bin};

  assign so    = so_r;
  assign so_oe = active & rd_on;

  always_ff @(posedge clk) begin
    if (mem_we) mem[addr[MEM_AW-1:0]] <= bin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_r <= 1'b0; hold_r <= 1'b1; held <= 1'b0; cs_eff <= 1'b1;
      st <= ST_OP; bcnt <= '0; abyte <= 1'b0; is_wr <= 1'b0;
      sh <= '0; addr <= '0; wel <= 1'b0; clr_wel <= 1'b0;
      srw <= '0; so_r <= 1'b0; rd_on <= 1'b0;
    end else begin
      sck_r  <= sck;
      hold_r <= hold_n;
      if (hold_n != hold_r && !sck) held <= ~hold_n;
      if (!held) cs_eff <= cs_n;

      if (cs_eff) begin
        st <= ST_OP; bcnt <= '0; abyte <= 1'b0; rd_on <= 1'b0;
      end else if (rise) begin
        sh   <= bin[6:0];
        bcnt <= bcnt + 3'd1;
        if (bcnt == 3'd7) begin
          unique case (st)
            ST_OP: begin
              st <= ST_SKIP;
              case (bin)
                8'h06: wel <= 1'b1;
                8'h04: wel <= 1'b0;
                8'h05: st <= ST_RSR;
                8'h01: begin st <= ST_WSR; clr_wel <= 1'b1; end
                8'h03: begin st <= ST_ADR; is_wr <= 1'b0; end
                8'h02: begin st <= ST_ADR; is_wr <= 1'b1; clr_wel <= 1'b1; end
                default: ;
              endcase
            end
            ST_ADR: begin
              addr  <= adr_sh[ADDR_W-1:0];
              abyte <= 1'b1;
              if (abyte) st <= is_wr ? ST_WR : ST_RD;
            end
            ST_WR, ST_RD: addr <= addr + 1'b1;
            ST_WSR: begin
              if (wel && wp_n) srw <= {bin[7], bin[3:2]};
              st <= ST_SKIP;
            end
            default: ;
          endcase
        end
      end else if (fall && (st == ST_RD || st == ST_RSR)) begin
        so_r  <= out_byte[~bcnt];
        rd_on <= 1'b1;
      end

      if (cs_rise) begin
        if (clr_wel) wel <= 1'b0;
        clr_wel <= 1'b0;
      end
    end
  end

  AST_CS_HIGH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n && $past(cs_n) && !$past(held) |-> !so_oe); // R8
  AST_WP_GUARDS_SR: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> $stable(srw)); // R6
  AST_NO_WEL_NO_SR: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WSR && !wel) |=> $stable(srw)); // R5
  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    held |=> $stable(st) && $stable(bcnt) && $stable(addr)); // R9
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (st == ST_RD || st == ST_WR)) |=> addr == ADDR_W'($past(addr) + 1'b1)); // R4
  AST_SO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(so_r)); // R12
  AST_WEL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && clr_wel) |=> !wel); // R7
endmodule

// File: tb/spi_nvram_slave_tb_top.sv
`timescale 1ns/1ps
module spi_nvram_slave_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic hold_n = 1'b1, wp_n = 1'b1;
  logic so, so_oe;
  int nchk = 0, nfail = 0;
  bit mode3 = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] mon_sh = '0;
  int mon_cnt = 0;

  spi_nvram_slave dut_i (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge sck) begin
    if (!cs_n && hold_n && so_oe === 1'b1) begin
      mon_sh = {mon_sh[6:0], so};
      mon_cnt++;
      if (mon_cnt == 8) begin
        mon_cnt = 0;
        nchk++;
        if (exp_q.size() == 0) begin
          nfail++;
          $display("FAIL R8 unexpected byte actual=%h expected=none", mon_sh);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (mon_sh !== e) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", t, mon_sh, e);
          end
        end
      end
    end
  end

  always @(posedge cs_n) if (hold_n) mon_cnt = 0;

  task automatic hp(); repeat (4) @(negedge clk); endtask
  task automatic sbit(input logic b); sck = 1'b0; si = b; hp(); sck = 1'b1; hp(); endtask
  task automatic sbyte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) sbit(b[i]);
  endtask
  task automatic bx(); cs_n = 1'b0; hp(); endtask
  task automatic ex(); if (!mode3) sck = 1'b0; hp(); cs_n = 1'b1; hp(); hp(); endtask
  task automatic expect_b(input logic [7:0] e, input string t); exp_q.push_back(e); tag_q.push_back(t); endtask
  task automatic cmd(input logic [7:0] op); bx(); sbyte(op); ex(); endtask
  task automatic rdsr(input logic [7:0] e, input string t);
    expect_b(e, t); bx(); sbyte(8'h05); sbyte(8'h00); ex();
  endtask
  task automatic wrsr(input logic [7:0] v); bx(); sbyte(8'h01); sbyte(v); ex(); endtask
  task automatic wr(input logic [15:0] a, input int n, input logic [7:0] d0, d1, d2);
    bx(); sbyte(8'h02); sbyte(a[15:8]); sbyte(a[7:0]);
    sbyte(d0); if (n > 1) sbyte(d1); if (n > 2) sbyte(d2);
    ex();
  endtask
  task automatic rd(input logic [15:0] a, input int n, input logic [7:0] e0, e1, e2, input string t);
    expect_b(e0, t); if (n > 1) expect_b(e1, t); if (n > 2) expect_b(e2, t);
    bx(); sbyte(8'h03); sbyte(a[15:8]); sbyte(a[7:0]);
    for (int i = 0; i < n; i++) sbyte(8'h00);
    ex();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hp();
    check("R1 oe after reset", so_oe, 0);
    rdsr(8'h00, "R1 status after reset");
    cmd(8'h06); rdsr(8'h02, "R2 wel set");
    cmd(8'h04); rdsr(8'h00, "R2 wel cleared");
    cmd(8'h06); wr(16'h0010, 3, 8'hA1, 8'hB2, 8'hC3);
    rdsr(8'h00, "R7 wel cleared after write");
    rd(16'h8010, 3, 8'hA1, 8'hB2, 8'hC3, "R3 burst read");
    check("R8 oe low with cs high", so_oe, 0);
    wr(16'h0011, 1, 8'hFF, 0, 0);
    rd(16'h0011, 1, 8'hB2, 0, 0, "R5 array write without wel");
    wrsr(8'h8C); rdsr(8'h00, "R5 status write without wel");
    cmd(8'h06); wrsr(8'h8C); rdsr(8'h8C, "R7 status written, wel dropped");
    wp_n = 1'b0;
    cmd(8'h06); wrsr(8'h00); rdsr(8'h8C, "R6 status protected");
    cmd(8'h06); wr(16'h0020, 1, 8'h77, 0, 0);
    rd(16'h0020, 1, 8'h77, 0, 0, "R6 array write with wp low");
    wp_n = 1'b1;
    cmd(8'h06); wr(16'h7FFE, 3, 8'h11, 8'h22, 8'h33);
    rd(16'h7FFE, 3, 8'h11, 8'h22, 8'h33, "R4 wrap burst");
    rd(16'h0000, 1, 8'h33, 0, 0, "R4 wrapped byte at zero");
    cmd(8'h06);
    bx(); sbyte(8'h02); sbyte(8'h00); sbyte(8'h10);
    sbit(0); sbit(1); sbit(0); sbit(1); ex();
    rd(16'h0010, 1, 8'hA1, 0, 0, "R11 partial byte discarded");
    bx(); sbit(1); sbit(1); sbit(1); ex();
    rdsr(8'h8C, "R11 decoder back to idle");
    mode3 = 1'b1; sck = 1'b1; hp();
    cmd(8'h06); wr(16'h0100, 1, 8'h3C, 0, 0);
    rd(16'h0100, 1, 8'h3C, 0, 0, "R12 mode 3 transfer");
    mode3 = 1'b0; sck = 1'b0; hp();
    expect_b(8'hA1, "R9 byte before hold"); expect_b(8'hB2, "R9 byte after hold");
    bx(); sbyte(8'h03); sbyte(8'h00); sbyte(8'h10); sbyte(8'h00);
    sbit(0); sbit(0); sbit(0);
    sck = 1'b0; hp(); hold_n = 1'b0; hp();
    check("R9 oe low in hold", so_oe, 0);
    sck = 1'b1; hp(); sck = 1'b0; hp();
    cs_n = 1'b1; hp(); cs_n = 1'b0; hp();
    check("R9 oe low after cs toggle in hold", so_oe, 0);
    hold_n = 1'b1; hp();
    for (int i = 0; i < 5; i++) sbit(0);
    ex();
    cmd(8'h06);
    bx(); sbyte(8'h02); sbyte(8'h00); sbyte(8'h30);
    sbit(1); sbit(0); sbit(0); sbit(1);
    hold_n = 1'b0; hp();
    check("R8 oe low during write", so_oe, 0);
    sbit(1); sbit(0); sbit(0); sbit(1);
    ex(); hold_n = 1'b1; hp();
    rd(16'h0030, 1, 8'h99, 0, 0, "R10 hold edge with sck high ignored");
    hp();
    check("R3 all expected bytes seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule